// File: doc/BRIEF.md
# Two-Channel IDE I/O Window Decoder

This block sits between a host I/O port bus and the two channels of an IDE controller. Every host access is matched against each channel's command window (eight bytes) and control window (four bytes). It then produces per-channel select lines for the task-file registers, the data port and the device-control/alternate-status port. The low nibble of the programming-interface configuration byte decides which address ranges are claimed. In compatibility mode the fixed legacy port ranges are decoded on top of the programmable base windows. In native mode only the programmable bases are decoded, and the reported interrupt-pin value becomes 1.

Access width is filtered per window. A rejected read still completes, but it returns all ones for its width. A rejected write is dropped. The registers behind the selects are only a stand-in stub: eight task-file bytes, one data word and one control byte per channel. They exist so that routing can be seen at the ports. Hit and select outputs are combinational. Read data is registered and appears, with a valid flag, one cycle after the read strobe.

Top module: `ide_chan_decoder`

## Requirements
- R1: Mode is sampled at each clock edge. A programming-interface low nibble of 0xA sets compatibility mode (`legacy_on`=1), 0xF sets native mode (`legacy_on`=0), and any other nibble leaves the mode unchanged.
- R2: `int_pin` is 0 while in compatibility mode and 1 while in native mode.
- R3: In compatibility mode, channel 0 claims command ports 0x1F0-0x1F7 and control ports 0x3F4-0x3F7, and channel 1 claims 0x170-0x177 and 0x374-0x377. The live control port is at 0x3F6 for channel 0 and 0x376 for channel 1.
- R4: In native mode no legacy port is claimed: no hit, no select and no `rd_valid`.
- R5: The programmable base windows are claimed in both modes. The command base is aligned to 8 bytes and the control base to 4 bytes.
- R6: In a control window, only a 1-byte access at offset 2 asserts `ctl_sel`. It reaches the channel's control byte.
- R7: Any other control-window read returns all ones for its width (0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2, 4), and any other control-window write changes nothing.
- R8: In a command window, a 1-byte access asserts `tf_sel` and reaches the task-file byte at offset `reg_off`. Byte reads are zero-extended.
- R9: In a command window, a 2-byte or 4-byte access asserts `dport_sel` only at offset 0. A 2-byte read returns the low half of the data word, zero-extended. A wide access at any other offset is rejected: a read returns all ones for its width and a write is dropped.
- R10: Hits and selects follow the current inputs in the same cycle. A read that hits any window loads `rd_data` and raises `rd_valid` for exactly the next cycle.
- R11: After reset the block is in native mode, `int_pin` is 1, and `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O port address |
| io_size | input | 3 | Access size in bytes (1, 2 or 4) |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 32 | Write data, little-endian lanes |
| pi_byte | input | 8 | Programming-interface configuration byte |
| cmd_base_0 | input | ADDR_W | Channel 0 native command base |
| ctl_base_0 | input | ADDR_W | Channel 0 native control base |
| cmd_base_1 | input | ADDR_W | Channel 1 native command base |
| ctl_base_1 | input | ADDR_W | Channel 1 native control base |
| legacy_on | output | 1 | Compatibility ranges are claimed |
| int_pin | output | 8 | Reported interrupt-pin value |
| cmd_hit | output | 2 | Access falls in a channel's command window |
| ctl_hit | output | 2 | Access falls in a channel's control window |
| tf_sel | output | 2 | Task-file byte selected |
| dport_sel | output | 2 | Data port selected |
| ctl_sel | output | 2 | Control byte selected |
| reg_off | output | 3 | Register offset within the window |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds a new read result |

## Verification
Every cycle, the checker checks that a mode nibble is tracked on the next edge and that other nibbles hold the mode. It also checks that the interrupt-pin value follows the mode, that no select fires for a size or offset that the window rule forbids, and that `rd_valid` follows exactly one cycle after a claimed read. Only the bench scenarios can show that the legacy ranges disappear in native mode while the programmable windows stay live in both modes. The same holds for the all-ones width of each rejected read and for dropped writes, which leave the stub registers unchanged when read back later.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
   localparam int DATA_W = 32;
   localparam logic [3:0] PI_COMPAT = 4'hA;
   localparam logic [3:0] PI_NATIVE = 4'hF;

   typedef enum logic {MODE_NATIVE = 1'b0, MODE_COMPAT = 1'b1} mode_e;

   // all-ones pattern for a rejected read of the given byte count
   function automatic logic [DATA_W-1:0] ones_for(input logic [2:0] sz);
      case (sz)
         3'd1:    return 32'h0000_00FF;
         3'd2:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic wide_ok(input logic [2:0] sz);
      return (sz == 3'd2) || (sz == 3'd4);
   endfunction
endpackage

// File: rtl/ide_mode_reg.sv
module ide_mode_reg
   import ide_dec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] pi_nib,
   output logic       legacy_on,
   output logic [7:0] int_pin
);
   mode_e mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  mode_q <= MODE_NATIVE;
      else if (pi_nib == PI_COMPAT) mode_q <= MODE_COMPAT;
      else if (pi_nib == PI_NATIVE) mode_q <= MODE_NATIVE;
   end

   assign legacy_on = (mode_q == MODE_COMPAT);
   assign int_pin   = (mode_q == MODE_COMPAT) ? 8'd0 : 8'd1;
endmodule

// File: rtl/ide_win_decode.sv
module ide_win_decode
   import ide_dec_pkg::*;
#(
   parameter int              ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] LEG_CMD = 16'h01F0,
   parameter logic [ADDR_W-1:0] LEG_CTL = 16'h03F4
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic              strobe,
   input  logic              legacy_on,
   input  logic [ADDR_W-1:0] nat_cmd,
   input  logic [ADDR_W-1:0] nat_ctl,
   output logic              cmd_hit,
   output logic              ctl_hit,
   output logic              tf_sel,
   output logic              dp_sel,
   output logic              ctl_sel
);
   localparam int CMD_LSB = 3;
   localparam int CTL_LSB = 2;

   logic cmd_match, ctl_match;

   always_comb begin
      cmd_match = (addr[ADDR_W-1:CMD_LSB] == nat_cmd[ADDR_W-1:CMD_LSB]) ||
                  (legacy_on && addr[ADDR_W-1:CMD_LSB] == LEG_CMD[ADDR_W-1:CMD_LSB]);
      ctl_match = (addr[ADDR_W-1:CTL_LSB] == nat_ctl[ADDR_W-1:CTL_LSB]) ||
                  (legacy_on && addr[ADDR_W-1:CTL_LSB] == LEG_CTL[ADDR_W-1:CTL_LSB]);
      cmd_hit = strobe && cmd_match;
      ctl_hit = strobe && ctl_match;
      tf_sel  = cmd_hit && (size == 3'd1);
      dp_sel  = cmd_hit && (addr[CMD_LSB-1:0] == '0) && wide_ok(size);
      ctl_sel = ctl_hit && (size == 3'd1) && (addr[CTL_LSB-1:0] == 2'd2);
   end
endmodule

// File: rtl/ide_chan_stub.sv
module ide_chan_stub
   import ide_dec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              tf_sel,
   input  logic              dp_sel,
   input  logic              ctl_sel,
   input  logic [2:0]        off,
   input  logic [2:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rval
);
   localparam int TF_N = 8;

   logic [7:0]        tf_q [TF_N];
   logic [DATA_W-1:0] dword_q;
   logic [7:0]        ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TF_N; i++) tf_q[i] <= '0;
         dword_q <= '0;
         ctl_q   <= '0;
      end else if (wr) begin
         if (tf_sel)  tf_q[off] <= wdata[7:0];
         if (dp_sel)  dword_q   <= (size == 3'd4) ? wdata : {16'h0, wdata[15:0]};
         if (ctl_sel) ctl_q     <= wdata[7:0];
      end
   end

   always_comb begin
      rval = '0;
      if (tf_sel)       rval = {24'h0, tf_q[off]};
      else if (dp_sel)  rval = (size == 3'd4) ? dword_q : {16'h0, dword_q[15:0]};
      else if (ctl_sel) rval = {24'h0, ctl_q};
   end
endmodule

// File: rtl/ide_chan_decoder.sv
module ide_chan_decoder
   import ide_dec_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              NUM_CH    = 2,
   parameter logic [ADDR_W-1:0] LEG_CMD_0 = 16'h01F0,
   parameter logic [ADDR_W-1:0] LEG_CTL_0 = 16'h03F4,
   parameter logic [ADDR_W-1:0] LEG_CMD_1 = 16'h0170,
   parameter logic [ADDR_W-1:0] LEG_CTL_1 = 16'h0374
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [2:0]        io_size,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [31:0]       io_wdata,
   input  logic [7:0]        pi_byte,
   input  logic [ADDR_W-1:0] cmd_base_0,
   input  logic [ADDR_W-1:0] ctl_base_0,
   input  logic [ADDR_W-1:0] cmd_base_1,
   input  logic [ADDR_W-1:0] ctl_base_1,
   output logic              legacy_on,
   output logic [7:0]        int_pin,
   output logic [1:0]        cmd_hit,
   output logic [1:0]        ctl_hit,
   output logic [1:0]        tf_sel,
   output logic [1:0]        dport_sel,
   output logic [1:0]        ctl_sel,
   output logic [2:0]        reg_off,
   output logic [31:0]       rd_data,
   output logic              rd_valid
);
   localparam int OFF_W = 3;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("ide_chan_decoder: exactly two channels are supported");
   end
   if (ADDR_W < 10) begin : g_bad_aw
      $error("ide_chan_decoder: ADDR_W too narrow for legacy ports");
   end
   if (LEG_CMD_0[2:0] != 3'd0 || LEG_CMD_1[2:0] != 3'd0 ||
       LEG_CTL_0[1:0] != 2'd0 || LEG_CTL_1[1:0] != 2'd0) begin : g_bad_align
      $error("ide_chan_decoder: legacy bases misaligned");
   end

   logic              strobe;
   logic [DATA_W-1:0] ch_rval [NUM_CH];
   logic [ADDR_W-1:0] nat_cmd [NUM_CH];
   logic [ADDR_W-1:0] nat_ctl [NUM_CH];

   assign strobe     = io_rd || io_wr;
   assign reg_off    = io_addr[OFF_W-1:0];
   assign nat_cmd[0] = cmd_base_0;
   assign nat_cmd[1] = cmd_base_1;
   assign nat_ctl[0] = ctl_base_0;
   assign nat_ctl[1] = ctl_base_1;

   ide_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .pi_nib    (pi_byte[3:0]),
      .legacy_on (legacy_on),
      .int_pin   (int_pin)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] LC = (g == 0) ? LEG_CMD_0 : LEG_CMD_1;
      localparam logic [ADDR_W-1:0] LT = (g == 0) ? LEG_CTL_0 : LEG_CTL_1;

      ide_win_decode #(.ADDR_W(ADDR_W), .LEG_CMD(LC), .LEG_CTL(LT)) u_dec (
         .addr      (io_addr),
         .size      (io_size),
         .strobe    (strobe),
         .legacy_on (legacy_on),
         .nat_cmd   (nat_cmd[g]),
         .nat_ctl   (nat_ctl[g]),
         .cmd_hit   (cmd_hit[g]),
         .ctl_hit   (ctl_hit[g]),
         .tf_sel    (tf_sel[g]),
         .dp_sel    (dport_sel[g]),
         .ctl_sel   (ctl_sel[g])
      );

      ide_chan_stub u_stub (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (io_wr),
         .tf_sel  (tf_sel[g]),
         .dp_sel  (dport_sel[g]),
         .ctl_sel (ctl_sel[g]),
         .off     (io_addr[OFF_W-1:0]),
         .size    (io_size),
         .wdata   (io_wdata),
         .rval    (ch_rval[g])
      );
   end

   logic              any_hit, accepted;
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      any_hit  = |cmd_hit || |ctl_hit;
      accepted = |tf_sel || |dport_sel || |ctl_sel;
      rd_next  = '0;
      for (int c = 0; c < NUM_CH; c++) rd_next |= ch_rval[c];
      if (!accepted) rd_next = ones_for(io_size);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= io_rd && any_hit;
         if (io_rd && any_hit) rd_data <= rd_next;
      end
   end
endmodule

// File: rtl/ide_chan_decoder_chk.sv
module ide_chan_decoder_chk #(
   parameter int ADDR_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [2:0]        io_size,
   input logic              io_rd,
   input logic [7:0]        pi_byte,
   input logic              legacy_on,
   input logic [7:0]        int_pin,
   input logic [1:0]        cmd_hit,
   input logic [1:0]        ctl_hit,
   input logic [1:0]        tf_sel,
   input logic [1:0]        dport_sel,
   input logic [1:0]        ctl_sel,
   input logic              rd_valid
);
   p_compat_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pi_byte[3:0] == 4'hA |=> legacy_on);
   p_native_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pi_byte[3:0] == 4'hF |=> !legacy_on);
   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pi_byte[3:0] != 4'hA && pi_byte[3:0] != 4'hF) |=> $stable(legacy_on));
   p_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int_pin == (legacy_on ? 8'd0 : 8'd1));
   p_ctl_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      |ctl_sel |-> (io_size == 3'd1 && io_addr[1:0] == 2'd2 && (ctl_sel & ~ctl_hit) == 2'b00));
   p_tf_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
      |tf_sel |-> (io_size == 3'd1 && (tf_sel & ~cmd_hit) == 2'b00));
   p_dport_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
      |dport_sel |-> (io_addr[2:0] == 3'd0 && (io_size == 3'd2 || io_size == 3'd4)));
   p_rd_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && (|cmd_hit || |ctl_hit)) |=> rd_valid);
   p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> !rd_valid);
endmodule

bind ide_chan_decoder ide_chan_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_addr   (io_addr),
   .io_size   (io_size),
   .io_rd     (io_rd),
   .pi_byte   (pi_byte),
   .legacy_on (legacy_on),
   .int_pin   (int_pin),
   .cmd_hit   (cmd_hit),
   .ctl_hit   (ctl_hit),
   .tf_sel    (tf_sel),
   .dport_sel (dport_sel),
   .ctl_sel   (ctl_sel),
   .rd_valid  (rd_valid)
);

// File: tb/test_ide_chan_decoder.sv
module test_ide_chan_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [2:0]  io_size = 3'd1;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [31:0] io_wdata = '0;
   logic [7:0]  pi_byte = 8'h00;
   logic        legacy_on, rd_valid;
   logic [7:0]  int_pin;
   logic [1:0]  cmd_hit, ctl_hit, tf_sel, dport_sel, ctl_sel;
   logic [2:0]  reg_off;
   logic [31:0] rd_data;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ide_chan_decoder i_ide_chan_decoder (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .pi_byte(pi_byte),
      .cmd_base_0(16'hC000), .ctl_base_0(16'hC008),
      .cmd_base_1(16'hC010), .ctl_base_1(16'hC018),
      .legacy_on(legacy_on), .int_pin(int_pin), .cmd_hit(cmd_hit),
      .ctl_hit(ctl_hit), .tf_sel(tf_sel), .dport_sel(dport_sel),
      .ctl_sel(ctl_sel), .reg_off(reg_off), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // sel = {cmd_hit, ctl_hit, tf_sel, dport_sel, ctl_sel}
   typedef struct packed {
      logic [3:0]  pi;
      logic [15:0] addr;
      logic [2:0]  size;
      logic        rd;
      logic        wr;
      logic [31:0] wdata;
      logic [9:0]  sel;
      logic        vld;
      logic [31:0] rdat;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{4'hF, 16'hC003, 3'd1, 1'b0, 1'b1, 32'h5A,       10'b01_00_01_00_00, 1'b0, 32'h0,        8'd8},  // R8
      '{4'hF, 16'hC003, 3'd1, 1'b1, 1'b0, 32'h0,        10'b01_00_01_00_00, 1'b1, 32'h5A,       8'd8},  // R8
      '{4'hF, 16'hC010, 3'd4, 1'b0, 1'b1, 32'h12345678, 10'b10_00_00_10_00, 1'b0, 32'h0,        8'd9},  // R9
      '{4'hF, 16'hC010, 3'd4, 1'b1, 1'b0, 32'h0,        10'b10_00_00_10_00, 1'b1, 32'h12345678, 8'd9},  // R9
      '{4'hF, 16'hC010, 3'd2, 1'b1, 1'b0, 32'h0,        10'b10_00_00_10_00, 1'b1, 32'h5678,     8'd9},  // R9
      '{4'hF, 16'hC012, 3'd2, 1'b1, 1'b0, 32'h0,        10'b10_00_00_00_00, 1'b1, 32'hFFFF,     8'd9},  // R9
      '{4'hF, 16'hC012, 3'd2, 1'b0, 1'b1, 32'h0,        10'b10_00_00_00_00, 1'b0, 32'h0,        8'd9},  // R9
      '{4'hF, 16'hC010, 3'd4, 1'b1, 1'b0, 32'h0,        10'b10_00_00_10_00, 1'b1, 32'h12345678, 8'd9},  // R9
      '{4'hF, 16'hC00A, 3'd1, 1'b0, 1'b1, 32'h0C,       10'b00_01_00_00_01, 1'b0, 32'h0,        8'd6},  // R6
      '{4'hF, 16'hC00A, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_01_00_00_01, 1'b1, 32'h0C,       8'd6},  // R6
      '{4'hF, 16'hC00B, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_01_00_00_00, 1'b1, 32'hFF,       8'd7},  // R7
      '{4'hF, 16'hC00A, 3'd2, 1'b1, 1'b0, 32'h0,        10'b00_01_00_00_00, 1'b1, 32'hFFFF,     8'd7},  // R7
      '{4'hF, 16'hC00A, 3'd2, 1'b0, 1'b1, 32'h33,       10'b00_01_00_00_00, 1'b0, 32'h0,        8'd7},  // R7
      '{4'hF, 16'hC008, 3'd1, 1'b0, 1'b1, 32'h44,       10'b00_01_00_00_00, 1'b0, 32'h0,        8'd7},  // R7
      '{4'hF, 16'hC00A, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_01_00_00_01, 1'b1, 32'h0C,       8'd7},  // R7
      '{4'hF, 16'h01F0, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_00_00_00_00, 1'b0, 32'h0,        8'd4},  // R4
      '{4'hF, 16'h03F6, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_00_00_00_00, 1'b0, 32'h0,        8'd4},  // R4
      '{4'hA, 16'h01F3, 3'd1, 1'b1, 1'b0, 32'h0,        10'b01_00_01_00_00, 1'b1, 32'h5A,       8'd3},  // R3
      '{4'hA, 16'h0173, 3'd1, 1'b1, 1'b0, 32'h0,        10'b10_00_10_00_00, 1'b1, 32'h0,        8'd3},  // R3
      '{4'hA, 16'h0376, 3'd1, 1'b0, 1'b1, 32'h02,       10'b00_10_00_00_10, 1'b0, 32'h0,        8'd3},  // R3
      '{4'hA, 16'hC01A, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_10_00_00_10, 1'b1, 32'h02,       8'd5},  // R5
      '{4'hA, 16'h03F6, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_01_00_00_01, 1'b1, 32'h0C,       8'd3},  // R3
      '{4'hA, 16'h0170, 3'd4, 1'b1, 1'b0, 32'h0,        10'b10_00_00_10_00, 1'b1, 32'h12345678, 8'd3},  // R3
      '{4'h5, 16'h01F3, 3'd1, 1'b1, 1'b0, 32'h0,        10'b01_00_01_00_00, 1'b1, 32'h5A,       8'd1},  // R1
      '{4'hF, 16'h01F3, 3'd1, 1'b1, 1'b0, 32'h0,        10'b00_00_00_00_00, 1'b0, 32'h0,        8'd4}   // R4
   };

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      string rq;
      rq = $sformatf("R%0d", v.req);
      pi_byte = {4'h0, v.pi};
      @(negedge clk);
      io_addr = v.addr; io_size = v.size; io_rd = v.rd; io_wr = v.wr; io_wdata = v.wdata;
      #1;
      check(rq, "selects", {22'h0, cmd_hit, ctl_hit, tf_sel, dport_sel, ctl_sel}, {22'h0, v.sel});
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0;
      check(rq, "rd_valid", {31'h0, rd_valid}, {31'h0, v.vld});
      if (v.vld) check(rq, "rd_data", rd_data, v.rdat);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", "legacy_on", {31'h0, legacy_on}, 32'h0);
      check("R11", "int_pin", {24'h0, int_pin}, 32'h1);
      check("R11", "rd_valid", {31'h0, rd_valid}, 32'h0);
      check("R11", "rd_data", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R1 / R2: mode follows nibble after one edge, other nibbles hold
      pi_byte = 8'h8A; @(negedge clk);
      check("R1", "legacy_on after A", {31'h0, legacy_on}, 32'h1);
      check("R2", "int_pin compat", {24'h0, int_pin}, 32'h0);
      pi_byte = 8'h03; @(negedge clk);
      check("R1", "legacy_on held", {31'h0, legacy_on}, 32'h1);
      pi_byte = 8'h0F; @(negedge clk);
      check("R1", "legacy_on after F", {31'h0, legacy_on}, 32'h0);
      check("R2", "int_pin native", {24'h0, int_pin}, 32'h1);

      // R10: rd_valid lasts one cycle, and is absent before the edge
      io_addr = 16'hC003; io_size = 3'd1; io_rd = 1'b1;
      #1 check("R10", "rd_valid before edge", {31'h0, rd_valid}, 32'h0);
      check("R10", "hit same cycle", {30'h0, cmd_hit}, 32'h1);
      @(negedge clk); io_rd = 1'b0;
      check("R10", "rd_valid pulse", {31'h0, rd_valid}, 32'h1);
      @(negedge clk);
      check("R10", "rd_valid drops", {31'h0, rd_valid}, 32'h0);
      check("R10", "rd_data holds", rd_data, 32'h5A);

      // R8: byte offset 7 of channel 1 via native window
      io_addr = 16'hC017; io_wr = 1'b1; io_wdata = 32'hA7;
      @(negedge clk); io_wr = 1'b0; io_rd = 1'b1;
      @(negedge clk); io_rd = 1'b0;
      check("R8", "tf byte 7 ch1", rd_data, 32'hA7);
      check("R8", "reg_off", {29'h0, reg_off}, 32'h7);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule